// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and presents one request line to a processor. Beside it, the block gives the 3-bit index of the pending input that should be serviced next. Software programs it through a byte-wide write port with two addresses. The command address carries three kinds of word, told apart by data bits: an initialization word and two operation words. One operation word issues end-of-interrupt commands. The other switches the special mask mode. The data address loads the mask register.

The initialization word selects edge or level sensing for all eight inputs together. It also clears the mask and returns the priority order to its fixed default, with input 0 highest and input 7 lowest. It empties the pending and in-service registers and leaves special mask mode. Until the first initialization word has been written, the request line stays low. When the processor acknowledges, the chosen input moves from pending to in-service. A non-specific end-of-interrupt then retires the highest-priority in-service input. It can also rotate the priority order so that the retired input becomes the lowest.

Top module: `pic_core`

## Requirements
- R1: A write with `addr`=0 and `wr_data[4]`=1 is the initialization word. With `addr`=0 and `wr_data[4]`=0, `wr_data[3]`=0 selects the command word and `wr_data[3]`=1 selects the mode word. A write with `addr`=1 loads the mask, and mask bit i blocks input i.
- R2: After reset, `int_req` stays low whatever the inputs do, until an initialization word has been written.
- R3: An initialization word clears the mask, pending and in-service registers. It restores the priority order 0 (highest) to 7 (lowest) and switches special mask mode off.
- R4: Bit 3 of the initialization word sets the sensing for all inputs at once: 0 selects edge sensing and 1 selects level sensing.
- R5: In edge mode an input becomes pending only on a low-to-high change. An input held high after being serviced does not request again.
- R6: In level mode an input is pending while it is high. If it falls before acknowledge, its request is withdrawn.
- R7: `int_req` is high when the highest-priority unmasked pending input ranks above every in-service input. `int_vec` then gives that input's index.
- R8: An `inta` pulse while `int_req` is high sets the in-service bit of `int_vec` and clears its pending bit.
- R9: A command word with bit 5 set clears the highest-priority in-service bit. If bit 7 is also set, the cleared input becomes the lowest priority and the inputs after it follow in circular order.
- R10: A mode word with bit 6 set loads bit 5 into special mask mode. In that mode, any unmasked pending input that is not in service raises `int_req`, whatever the in-service priorities are.
- R11: An initialization word with any of bits 7..5 set or with bit 0 clear is still applied. In that case it sets `init_bad`. A conforming initialization word clears `init_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 1 | 0 selects the command address, 1 selects the mask |
| wr_data | input | 8 | Write data |
| irq_in | input | 8 | Interrupt request inputs |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 3 | Index of the input to service |
| init_bad | output | 1 | Last initialization word broke the fixed-bit rules |

## Verification
Most internal faults in this block show up as a wrong `int_req` or `int_vec` one cycle after the stimulus that exposes them. A stale in-service bit keeps `int_req` low for lower inputs after an end-of-interrupt. A wrong rotation pointer gives the wrong index as soon as two inputs are pending together. A missing edge detector re-raises `int_req` right after the in-service bit clears, while the input is still high. Faults in the mask or in special mask mode appear on the first pending input that the mask or the mode should pass or block.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned NUM_IRQ = 8;
    localparam int unsigned IDX_W   = $clog2(NUM_IRQ);

    typedef struct packed {
        logic               done;
        logic               level;
        logic               smm;
        logic               bad;
        logic [IDX_W-1:0]   low;
        logic [NUM_IRQ-1:0] imr;
        logic [NUM_IRQ-1:0] irr;
        logic [NUM_IRQ-1:0] isr;
        logic [NUM_IRQ-1:0] prev;
    } pic_state_t;

    typedef struct packed {
        logic init_wr;
        logic cmd_wr;
        logic mode_wr;
        logic mask_wr;
    } pic_cmd_t;
endpackage

// File: rtl/pic_decode.sv
module pic_decode #(
    parameter int unsigned DW = 8
) (
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wr_data,
    output pic_pkg::pic_cmd_t cmd
);
    always_comb begin
        cmd         = '0;
        cmd.mask_wr = wr_en && addr;
        cmd.init_wr = wr_en && !addr && wr_data[4];
        cmd.cmd_wr  = wr_en && !addr && !wr_data[4] && !wr_data[3];
        cmd.mode_wr = wr_en && !addr && !wr_data[4] && wr_data[3];
    end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] low,
    output logic         hit,
    output logic [W-1:0] pos,
    output logic [W-1:0] rank
);
    // Scan from the highest rank (just after the lowest) around the ring;
    // descending loop so the highest-ranked set bit is written last.
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [W-1:0] idx;
            idx = low + W'(1) + W'(k);
            if (vec[idx]) begin
                hit = 1'b1;
                pos = idx;
            end
        end
        rank = pos - low - W'(1);
    end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
    parameter int unsigned NI = pic_pkg::NUM_IRQ,
    localparam int unsigned VW = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [7:0]    wr_data,
    input  logic [NI-1:0] irq_in,
    input  logic          inta,
    output logic          int_req,
    output logic [VW-1:0] int_vec,
    output logic          init_bad
);
    import pic_pkg::*;

    pic_state_t s_d, s_q;
    pic_cmd_t   cmd;

    logic [NI-1:0] cand;
    logic          req_hit, isr_hit;
    logic [VW-1:0] req_pos, req_rank, isr_pos, isr_rank;
    logic          ack_go;
    logic [NI-1:0] imr_w, isr_w;
    logic          init_done_w;

    pic_decode #(.DW(8)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    assign cand = s_q.smm ? (s_q.irr & ~s_q.imr & ~s_q.isr)
                          : (s_q.irr & ~s_q.imr);

    pic_resolve #(.N(NI)) u_req (
        .vec  (cand),
        .low  (s_q.low),
        .hit  (req_hit),
        .pos  (req_pos),
        .rank (req_rank)
    );

    pic_resolve #(.N(NI)) u_isr (
        .vec  (s_q.isr),
        .low  (s_q.low),
        .hit  (isr_hit),
        .pos  (isr_pos),
        .rank (isr_rank)
    );

    assign int_req  = s_q.done && req_hit &&
                      (s_q.smm || !isr_hit || (req_rank < isr_rank));
    assign int_vec  = req_pos;
    assign init_bad = s_q.bad;
    assign ack_go   = inta && int_req;

    assign imr_w       = s_q.imr;
    assign isr_w       = s_q.isr;
    assign init_done_w = s_q.done;

    always_comb begin
        s_d      = s_q;
        s_d.prev = irq_in;

        if (s_q.level) s_d.irr = irq_in;
        else           s_d.irr = s_q.irr | (irq_in & ~s_q.prev);

        if (cmd.cmd_wr && wr_data[5] && isr_hit) begin
            s_d.isr[isr_pos] = 1'b0;
            if (wr_data[7]) s_d.low = isr_pos;
        end

        if (ack_go) begin
            s_d.irr[req_pos] = 1'b0;
            s_d.isr[req_pos] = 1'b1;
        end

        if (cmd.mode_wr && wr_data[6]) s_d.smm = wr_data[5];
        if (cmd.mask_wr)               s_d.imr = wr_data[NI-1:0];

        if (cmd.init_wr) begin
            s_d.done  = 1'b1;
            s_d.level = wr_data[3];
            s_d.smm   = 1'b0;
            s_d.bad   = (wr_data[7:5] != 3'b000) || !wr_data[0];
            s_d.low   = '1;
            s_d.imr   = '0;
            s_d.irr   = '0;
            s_d.isr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
    parameter int unsigned NI = 8,
    localparam int unsigned VW = $clog2(NI)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          addr,
    input logic [7:0]    wr_data,
    input logic          inta,
    input logic          int_req,
    input logic [VW-1:0] int_vec,
    input logic          init_bad,
    input logic          init_done,
    input logic [NI-1:0] imr,
    input logic [NI-1:0] isr
);
    a_r2_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !int_req);

    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[4]) |=> (imr == '0 && isr == '0 && init_done));

    a_r7_vec_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !imr[int_vec]);

    a_r8_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_req && !wr_en) |=> isr[$past(int_vec)]);

    a_r11_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[4]) |=>
        (init_bad == (($past(wr_data[7:5]) != 3'b000) || !$past(wr_data[0]))));
endmodule

bind pic_core pic_core_chk #(.NI(NI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .inta      (inta),
    .int_req   (int_req),
    .int_vec   (int_vec),
    .init_bad  (init_bad),
    .init_done (init_done_w),
    .imr       (imr_w),
    .isr       (isr_w)
);

// File: tb/pic_core_test.sv
module pic_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] irq_in = 8'h00;
    logic       inta = 1'b0;
    logic       int_req;
    logic [2:0] int_vec;
    logic       init_bad;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pic_core uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .irq_in   (irq_in),
        .inta     (inta),
        .int_req  (int_req),
        .int_vec  (int_vec),
        .init_bad (init_bad)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected request state; the index is compared only when a request is expected.
    task automatic chk_irq(input string req, input logic exp_req, input int exp_vec);
        if (exp_req) chk(req, {int_req, int_vec}, {1'b1, 3'(exp_vec)});
        else         chk(req, int_req, 0);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0; wr_data = 8'h00;
    endtask

    task automatic ack();
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_irq("R2 after reset", 1'b0, 0);
        chk("R11 flag after reset", init_bad, 0);
        drive(8'hFF);
        chk_irq("R2 inputs high before init", 1'b0, 0);
        drive(8'h00);
    endtask

    task automatic t_edge();
        wr(1'b0, 8'h11);
        chk("R11 legal init", init_bad, 0);
        chk_irq("R3 nothing pending after init", 1'b0, 0);
        drive(8'h08);
        chk_irq("R5 rising edge latched", 1'b1, 3);
        drive(8'h0A);
        chk_irq("R7 higher input wins", 1'b1, 1);
        ack();
        chk_irq("R8 lower pending blocked by in-service", 1'b0, 0);
        wr(1'b0, 8'h28);
        chk_irq("R1 mode word is not end-of-interrupt", 1'b0, 0);
        wr(1'b0, 8'h20);
        chk_irq("R9 eoi releases lower input", 1'b1, 3);
        ack();
        chk_irq("R8 ack clears pending", 1'b0, 0);
        wr(1'b0, 8'h20);
        chk_irq("R5 held-high input does not re-request", 1'b0, 0);
        drive(8'h00);
    endtask

    task automatic t_mask();
        wr(1'b1, 8'h04);
        drive(8'h04);
        chk_irq("R1 masked input blocked", 1'b0, 0);
        wr(1'b1, 8'h00);
        chk_irq("R1 unmask exposes pending", 1'b1, 2);
        ack();
        wr(1'b0, 8'h20);
        drive(8'h00);
    endtask

    task automatic t_level();
        wr(1'b0, 8'h19);
        chk("R11 legal level init", init_bad, 0);
        drive(8'h20);
        chk_irq("R6 level input pending", 1'b1, 5);
        drive(8'h00);
        chk_irq("R6 dropped input withdrawn", 1'b0, 0);
        drive(8'h20);
        ack();
        chk_irq("R8 level input in service", 1'b0, 0);
        wr(1'b0, 8'h20);
        chk_irq("R4 level mode re-requests while high", 1'b1, 5);
        drive(8'h00);
        chk_irq("R6 drop after eoi", 1'b0, 0);
    endtask

    task automatic t_rotate();
        wr(1'b0, 8'h11);
        drive(8'h04);
        chk_irq("R4 edge mode back", 1'b1, 2);
        ack();
        wr(1'b0, 8'hA0);
        drive(8'h00);
        drive(8'h14);
        chk_irq("R9 rotated input is lowest", 1'b1, 4);
    endtask

    task automatic t_reinit_smm();
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h11);
        chk_irq("R3 pending cleared by init", 1'b0, 0);
        drive(8'h00);
        drive(8'h81);
        chk_irq("R3 mask cleared and order reset", 1'b1, 0);
        ack();
        chk_irq("R7 input 7 below in-service 0", 1'b0, 0);
        wr(1'b0, 8'h68);
        chk_irq("R10 special mask mode passes lower input", 1'b1, 7);
        wr(1'b0, 8'h48);
        chk_irq("R10 special mask mode off", 1'b0, 0);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h11);
        drive(8'h00);
        drive(8'h81);
        ack();
        chk_irq("R3 init leaves special mask mode", 1'b0, 0);
        drive(8'h00);
    endtask

    task automatic t_bad();
        wr(1'b0, 8'h90);
        chk("R11 illegal init flagged", init_bad, 1);
        drive(8'h02);
        chk_irq("R11 illegal init still applied", 1'b1, 1);
        wr(1'b0, 8'h11);
        chk("R11 flag cleared by legal init", init_bad, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_mask();
        t_level();
        t_rotate();
        t_reinit_smm();
        t_bad();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule